// File: doc/BRIEF.md
# Program/Erase Busy Status Reporter

This block forms the byte a host sees when it reads a flash-style memory while a program or erase is running inside it. A one-cycle start pulse begins an operation. The pulse carries the kind of operation and, for a program, the byte being written. An internal timer keeps a busy flag high for a fixed number of clock cycles, and each kind of operation has its own count.

While busy, every read strobe returns a status byte. Bit 7 is the inverse of bit 7 of the byte being programmed, and it reads 0 during an erase. Bit 6 flips on every read, and the first read after the start is included. Bits 5..0 carry the array data. Once busy falls, reads return the true array byte on all eight bits, so bit 6 stops changing.

A host polls until bit 7 matches the written value or until bit 6 stops flipping. The block holds no array storage and decodes no commands.

Top module: `busy_poll_reporter`

## Requirements
- R1: After synchronous reset, `busy` is 0, `rd_data` is 0x00 and the internal toggle state is 0. The first read strobe issued during a later operation therefore returns bit 6 = 0.
- R2: A `start` pulse while idle raises `busy` on the next clock edge. `busy` then stays high for exactly PROG_CYCLES cycles when `op_kind` = 0 (program) or ERASE_CYCLES cycles when `op_kind` = 1 (erase).
- R3: A `start` pulse while `busy` is high is ignored: the timer, the operation kind and the pending byte all stay as they were.
- R4: During a program, a read returns bit 7 equal to the inverse of bit 7 of the byte given with `start`.
- R5: During an erase, a read returns bit 7 = 0.
- R6: While busy, each read strobe returns bit 6 inverted from the previous read made while busy. Cycles without a read strobe leave the toggle state unchanged.
- R7: While busy, bits 5..0 of a read return `array_data[5:0]`.
- R8: While idle, a read returns `array_data` on all eight bits. Repeated idle reads of a constant array byte return a constant bit 6.
- R9: `rd_data` is registered. It takes its new value on the clock edge that samples `rd_strobe` and holds that value in cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins an operation |
| op_kind | input | 1 | Kind of operation: 0 = program, 1 = erase |
| load_data | input | DW | Byte being programmed, sampled with `start` |
| rd_strobe | input | 1 | Read request, one per cycle |
| array_data | input | DW | True array contents at the read address |
| busy | output | 1 | High while an operation is timed |
| rd_data | output | DW | Registered read result |

## Verification
The assertions take for granted that `start`, `op_kind`, `load_data`, `rd_strobe` and `array_data` are synchronous to `clk` and settled at each rising edge. They also assume that a read in the same cycle as an accepted `start` still sees the idle state.

The stimulus drives every input on the falling edge. It fires a start pulse while busy to exercise R3, and it spaces reads irregularly so that R6 is tested against non-read cycles. The array byte changes every cycle, except in one phase that holds it constant so that idle reads can show a steady bit 6.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/bsr_op_timer.sv
module bsr_op_timer #(
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  bsr_pkg::op_kind_e kind_in,
  input  logic [DW-1:0]    data_in,
  output logic             busy,
  output bsr_pkg::op_kind_e kind_q,
  output logic [DW-1:0]    pend_q
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      kind_q <= bsr_pkg::OP_PROG;
      pend_q <= '0;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end else if (start) begin
      busy   <= 1'b1;
      kind_q <= kind_in;
      pend_q <= data_in;
      remain <= (kind_in == bsr_pkg::OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
    end
  end

  // R2: busy only rises after an accepted start
  p_rise_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R3: a start during busy leaves the latched operation unchanged
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(kind_q) && $stable(pend_q)));
endmodule

// File: rtl/bsr_toggle.sv
module bsr_toggle (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic tgl
);
  always_ff @(posedge clk) begin
    if (rst)          tgl <= 1'b0;
    else if (advance) tgl <= ~tgl;
  end

  // R6: each busy read flips, otherwise held
  p_flip_on_read_r6: assert property (@(posedge clk) disable iff (rst)
    advance |=> (tgl != $past(tgl)));
  p_hold_no_read_r6: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(tgl));
endmodule

// File: rtl/bsr_status_mux.sv
module bsr_status_mux #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  input  logic              busy,
  input  bsr_pkg::op_kind_e kind_q,
  input  logic [DW-1:0]     pend_q,
  input  logic              tgl,
  input  logic [DW-1:0]     array_data,
  output logic [DW-1:0]     rd_data
);
  localparam int POLL_BIT = DW - 1;
  localparam int TGL_BIT  = DW - 2;

  logic [DW-1:0] status_word;

  always_comb begin
    status_word           = array_data;
    status_word[TGL_BIT]  = tgl;
    status_word[POLL_BIT] = (kind_q == bsr_pkg::OP_ERASE) ? 1'b0 : ~pend_q[POLL_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_data <= '0;
    else if (rd_strobe) rd_data <= busy ? status_word : array_data;
  end

  // R5: erase polls read bit 7 low
  p_erase_poll_low_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && busy && kind_q == bsr_pkg::OP_ERASE) |=> !rd_data[POLL_BIT]);
  // R4: program polls read inverted bit 7
  p_prog_poll_inv_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && busy && kind_q == bsr_pkg::OP_PROG) |=> (rd_data[POLL_BIT] == !$past(pend_q[POLL_BIT])));
  // R9: output holds without a strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rd_data));
endmodule

// File: rtl/busy_poll_reporter.sv
module busy_poll_reporter #(
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_kind,
  input  logic [DW-1:0] load_data,
  input  logic          rd_strobe,
  input  logic [DW-1:0] array_data,
  output logic          busy,
  output logic [DW-1:0] rd_data
);
  bsr_pkg::op_kind_e kind_q;
  logic [DW-1:0]     pend_q;
  logic              tgl;

  bsr_op_timer #(.DW(DW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start),
    .kind_in(bsr_pkg::op_kind_e'(op_kind)), .data_in(load_data),
    .busy(busy), .kind_q(kind_q), .pend_q(pend_q)
  );

  bsr_toggle u_toggle (
    .clk(clk), .rst(rst), .advance(rd_strobe & busy), .tgl(tgl)
  );

  bsr_status_mux #(.DW(DW)) u_mux (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .busy(busy), .kind_q(kind_q),
    .pend_q(pend_q), .tgl(tgl), .array_data(array_data), .rd_data(rd_data)
  );

  // R8: idle reads pass the array byte unchanged
  p_idle_true_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !busy) |=> (rd_data == $past(array_data)));
  // R7: low bits pass through during busy
  p_low_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && busy) |=> (rd_data[DW-3:0] == $past(array_data[DW-3:0])));
endmodule

// File: tb/sim_busy_poll_reporter.sv
`timescale 1ns/1ps
module sim_busy_poll_reporter;
  localparam int DW = 8;
  localparam int PC = 20;
  localparam int EC = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic op_kind = 1'b0;
  logic [DW-1:0] load_data = '0;
  logic rd_strobe = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic busy;
  logic [DW-1:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  bit hold_arr = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  busy_poll_reporter #(.DW(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_kind(op_kind), .load_data(load_data),
    .rd_strobe(rd_strobe), .array_data(array_data), .busy(busy), .rd_data(rd_data)
  );

  // behavioural reference model
  int m_busy = 0, m_rem = 0, m_tgl = 0, m_kind = 0, m_pend = 0, m_rd = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_rem = 0; m_tgl = 0; m_kind = 0; m_pend = 0; m_rd = 0;
    end else begin
      if (rd_strobe) begin
        if (m_busy != 0) begin
          int b7;
          b7 = (m_kind == 1) ? 0 : (((m_pend >> 7) & 1) ^ 1);
          m_rd = (b7 << 7) | (m_tgl << 6) | (int'(array_data) & 63);
          m_tgl = m_tgl ^ 1;
        end else m_rd = int'(array_data);
      end
      if (m_busy != 0) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) m_busy = 0;
      end else if (start) begin
        m_busy = 1; m_kind = int'(op_kind); m_pend = int'(load_data);
        m_rem = (op_kind == 1'b1) ? EC : PC;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, int'(busy), m_busy, "busy");
      check(cur_req, int'(rd_data), m_rd, "rd_data");
    end
  end

  // array byte changes every cycle unless held
  always @(negedge clk) if (!hold_arr) array_data <= array_data + 8'd37;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_op(input logic k, input logic [DW-1:0] d);
    @(negedge clk); start = 1'b1; op_kind = k; load_data = d;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic read1;
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  initial begin
    int cnt;
    int prev6;
    cyc(3);
    // R1 reset state
    check("R1", int'(busy), 0, "busy after reset");
    check("R1", int'(rd_data), 0, "rd_data after reset");
    @(negedge clk); rst = 1'b0;

    // R8 idle reads
    cur_req = "R8";
    for (int i = 0; i < 4; i++) read1();

    // R2 / R4 program duration and polling, first read gets bit6=0 (R1)
    cur_req = "R4";
    begin_op(1'b0, 8'h5A);
    check("R2", int'(busy), 1, "busy after start");
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    check("R1", int'(rd_data[6]), 0, "first busy read bit6");
    check("R4", int'(rd_data[7]), 1, "program poll bit7");
    cnt = 3;
    prev6 = int'(rd_data[6]);
    cur_req = "R6";
    while (busy) begin
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
      if (busy || cnt < PC) begin
        check("R6", int'(rd_data[6]), prev6 ^ 1, "bit6 flip per read");
        prev6 = int'(rd_data[6]);
      end
      cnt += 2;
      cyc(1); cnt++;
    end
    cnt = 0;

    // R2 exact program length, measured from accept
    cur_req = "R2";
    begin_op(1'b0, 8'hC3);
    cnt = 1;
    while (busy) begin @(negedge clk); cnt += int'(busy); end
    check("R2", cnt, PC, "program busy length");

    // R5 / R3 erase with a start during busy
    cur_req = "R5";
    begin_op(1'b1, 8'h00);
    for (int i = 0; i < 5; i++) read1();
    cur_req = "R3";
    begin_op(1'b0, 8'h00);
    read1();
    check("R3", int'(rd_data[7]), 0, "erase kind kept after ignored start");
    cnt = 0;
    cur_req = "R7";
    while (busy) begin
      @(negedge clk); rd_strobe = cnt[0];
      cnt++;
    end
    @(negedge clk); rd_strobe = 1'b0;

    // R8 toggle constant after busy falls, array held
    cur_req = "R8";
    hold_arr = 1;
    array_data = 8'hB4;
    for (int i = 0; i < 4; i++) begin
      read1();
      check("R8", int'(rd_data[6]), 0, "idle bit6 constant");
      check("R8", int'(rd_data), 8'hB4, "idle true data");
    end
    hold_arr = 0;

    // R9 hold without strobe
    cur_req = "R9";
    begin_op(1'b0, 8'h0F);
    read1();
    prev6 = int'(rd_data);
    cyc(4);
    check("R9", int'(rd_data), prev6, "rd_data held without strobe");
    while (busy) cyc(1);
    cyc(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule